// File: doc/BRIEF.md
# Double-Buffered UART Transmitter

This block is the sending half of a UART. A bus master writes 8-bit characters into a holding register. A separate shift register sends each character on a serial line as an 8N1 frame. Because there are two stages, the master can queue the next character while the current one is still being sent. A ready flag tells the master when the holding stage can accept another character.

A bus write clears the ready flag. The flag is set again only on the clock edge where the shift register takes the held character. The shift register takes a character when three things are true: it is idle, a character is held, and the transmitter is enabled. A write that arrives while the flag is clear behaves in one of two ways. If the transmitter is enabled, the write replaces the held character. If the transmitter is disabled, the write is dropped. Bit timing comes from an external baud tick, and each bit lasts a fixed number of ticks.

Top module: `uart_tx_dbuf`

## Requirements
- R1: After reset, `rdy_o` is 1, `tx_o` is 1 (idle) and `empty_o` is 1.
- R2: A write while `rdy_o` is 1 stores `wr_data_i` in the holding register and clears `rdy_o` on the next clock edge.
- R3: When the shifter is idle, a character is held and `en_i` is 1, the shifter takes the held character and `rdy_o` returns to 1 on that same edge. With an idle shifter, `rdy_o` therefore stays low for exactly one cycle after a write.
- R4: A frame is one low start bit, then data bits 0 to 7 in that order (LSB first), then one high stop bit. Each bit lasts 16 baud ticks.
- R5: A write while `rdy_o` is 0 and `en_i` is 0 is dropped. The character held before the write is the one sent later.
- R6: A write while `rdy_o` is 0 and `en_i` is 1 replaces the held character, and `rdy_o` stays 0.
- R7: While `en_i` is 0, no character is loaded into the shifter. A frame already being sent still completes, and `tx_o` then stays high.
- R8: `empty_o` is 1 exactly when no frame is being sent and no character is held.
- R9: `tx_o` changes only when a frame starts or on a clock edge where `baud_tick_i` is 1. Between ticks it holds its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Bus write strobe for the transmit buffer |
| wr_data_i | input | 8 | Character to write |
| en_i | input | 1 | Transmitter enable |
| baud_tick_i | input | 1 | One-cycle pulse; 16 pulses make one bit time |
| rdy_o | output | 1 | Holding register can accept a character |
| tx_o | output | 1 | Serial output line, idles high |
| empty_o | output | 1 | No frame in progress and nothing held |

## Verification
The hardest case to reach from the ports is a write made while the ready flag is clear and the transmitter is disabled. With an idle shifter, the flag is clear for only one cycle, so the bench first drops the enable. It then writes once so that the character stays held with the flag low, and writes a second character that must be dropped. The replace case is reached differently: one character is kept in the shifter by withholding baud ticks, then two writes are made back to back. The frame that is sent afterwards shows which character survived.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  parameter int unsigned DATA_W        = 8;
  parameter int unsigned TICKS_PER_BIT = 16;

  typedef enum logic {
    SH_IDLE = 1'b0,
    SH_SEND = 1'b1
  } sh_state_e;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned DATA_W = uart_tx_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              en_i,
  input  logic              take_i,
  output logic              rdy_o,
  output logic [DATA_W-1:0] hold_o
);
  logic accept;

  // Accepted when free, or when enabled (overwrite of a pending char)
  assign accept = wr_i && (rdy_o || en_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_o <= '0;
      rdy_o  <= 1'b1;
    end else begin
      if (accept) hold_o <= wr_data_i;
      if (accept)      rdy_o <= 1'b0;
      else if (take_i) rdy_o <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_shift.sv
module uart_tx_shift
  import uart_tx_pkg::*;
#(
  parameter int unsigned DATA_W        = uart_tx_pkg::DATA_W,
  parameter int unsigned TICKS_PER_BIT = uart_tx_pkg::TICKS_PER_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              tick_i,
  output logic              busy_o,
  output logic              tx_o
);
  localparam int unsigned FRAME_W = DATA_W + 2;
  localparam int unsigned CNT_W   = (TICKS_PER_BIT > 1) ? $clog2(TICKS_PER_BIT) : 1;
  localparam int unsigned BIT_W   = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TICKS_PER_BIT - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  sh_state_e          state_q;
  logic [FRAME_W-1:0] sreg_q;
  logic [CNT_W-1:0]   tick_cnt_q;
  logic [BIT_W-1:0]   bit_cnt_q;
  logic               bit_end;

  assign bit_end = tick_i && (tick_cnt_q == CNT_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= SH_IDLE;
      sreg_q     <= '1;
      tick_cnt_q <= '0;
      bit_cnt_q  <= '0;
    end else begin
      unique case (state_q)
        SH_IDLE: if (load_i) begin
          // stop, data, start; bit 0 goes out first
          sreg_q     <= {1'b1, data_i, 1'b0};
          tick_cnt_q <= '0;
          bit_cnt_q  <= '0;
          state_q    <= SH_SEND;
        end
        SH_SEND: if (tick_i) begin
          tick_cnt_q <= bit_end ? '0 : tick_cnt_q + 1'b1;
          if (bit_end) begin
            sreg_q    <= {1'b1, sreg_q[FRAME_W-1:1]};
            bit_cnt_q <= bit_cnt_q + 1'b1;
            if (bit_cnt_q == BIT_LAST) state_q <= SH_IDLE;
          end
        end
        default: state_q <= SH_IDLE;
      endcase
    end
  end

  assign busy_o = (state_q == SH_SEND);
  assign tx_o   = busy_o ? sreg_q[0] : 1'b1;
endmodule

// File: rtl/uart_tx_dbuf.sv
module uart_tx_dbuf #(
  parameter int unsigned DATA_W        = uart_tx_pkg::DATA_W,
  parameter int unsigned TICKS_PER_BIT = uart_tx_pkg::TICKS_PER_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              en_i,
  input  logic              baud_tick_i,
  output logic              rdy_o,
  output logic              tx_o,
  output logic              empty_o
);
  logic              busy;
  logic              take;
  logic [DATA_W-1:0] hold;

  // Hand-off: shifter idle, char pending (rdy low), transmitter enabled
  assign take    = !busy && !rdy_o && en_i;
  assign empty_o = !busy && rdy_o;

  uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .wr_data_i (wr_data_i),
    .en_i      (en_i),
    .take_i    (take),
    .rdy_o     (rdy_o),
    .hold_o    (hold)
  );

  uart_tx_shift #(.DATA_W(DATA_W), .TICKS_PER_BIT(TICKS_PER_BIT)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (take),
    .data_i (hold),
    .tick_i (baud_tick_i),
    .busy_o (busy),
    .tx_o   (tx_o)
  );
endmodule

// File: rtl/uart_tx_dbuf_chk.sv
module uart_tx_dbuf_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic wr_i,
  input logic en_i,
  input logic baud_tick_i,
  input logic rdy_o,
  input logic tx_o,
  input logic empty_o
);
  assert_wr_clears_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && rdy_o) |=> !rdy_o);

  assert_rdy_rise_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> ($past(en_i) && !$past(wr_i)));

  assert_start_low_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> !tx_o);

  assert_drop_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && !en_i && wr_i) |=> !rdy_o);

  assert_no_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rdy_o && !en_i) |=> !rdy_o);

  assert_empty_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> (rdy_o && tx_o));

  assert_rise_on_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_o) |-> $past(baud_tick_i));
endmodule

bind uart_tx_dbuf uart_tx_dbuf_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_i        (wr_i),
  .en_i        (en_i),
  .baud_tick_i (baud_tick_i),
  .rdy_o       (rdy_o),
  .tx_o        (tx_o),
  .empty_o     (empty_o)
);

// File: tb/sim_uart_tx_dbuf.sv
`timescale 1ns/1ps
module sim_uart_tx_dbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdat = '0;
  logic       en = 1'b0;
  logic       tick = 1'b0;
  logic       rdy, tx, empty;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  uart_tx_dbuf u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wr_data_i(wdat), .en_i(en),
    .baud_tick_i(tick), .rdy_o(rdy), .tx_o(tx), .empty_o(empty)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
    end
  endtask

  task automatic write(input logic [7:0] d);
    wr = 1'b1; wdat = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  // Starts with the start bit on the line; ends right after the stop bit.
  task automatic frame(input logic [7:0] d, input string req);
    for (int b = 0; b < 10; b++) begin
      logic e;
      e = (b == 0) ? 1'b0 : (b == 9) ? 1'b1 : d[b-1];
      chk(req, tx, e);
      pulse(15);
      chk({req, " mid-bit"}, tx, e);
      pulse(1);
    end
    chk({req, " stop end idle"}, tx, 1'b1);
  endtask

  task automatic t_reset;
    chk("R1 rdy", rdy, 1'b1);
    chk("R1 tx", tx, 1'b1);
    chk("R1 empty", empty, 1'b1);
  endtask

  task automatic t_basic;
    en = 1'b1;
    write(8'hA6);
    chk("R2 rdy cleared", rdy, 1'b0);
    chk("R8 empty low with held char", empty, 1'b0);
    idle(1);
    chk("R3 rdy back after take", rdy, 1'b1);
    chk("R4 start bit", tx, 1'b0);
    chk("R8 empty low while sending", empty, 1'b0);
    frame(8'hA6, "R4 frame A6");
    chk("R8 empty after frame", empty, 1'b1);
  endtask

  task automatic t_no_tick;
    write(8'h01);
    idle(1);
    chk("R9 start", tx, 1'b0);
    idle(40);
    chk("R9 line holds without ticks", tx, 1'b0);
    pulse(16);
    chk("R9 data bit0 after 16 ticks", tx, 1'b1);
    idle(30);
    chk("R9 holds level", tx, 1'b1);
    pulse(16);
    chk("R4 data bit1", tx, 1'b0);
    pulse(16 * 8);
    chk("R8 empty after frame 01", empty, 1'b1);
  endtask

  task automatic t_drop;
    en = 1'b0;
    write(8'h5A);
    chk("R2 rdy cleared disabled", rdy, 1'b0);
    write(8'hFF);
    idle(10);
    chk("R7 no load while disabled rdy", rdy, 1'b0);
    chk("R7 line idle while disabled", tx, 1'b1);
    en = 1'b1;
    idle(1);
    chk("R3 take on enable", rdy, 1'b1);
    frame(8'h5A, "R5 dropped write, frame 5A");
  endtask

  task automatic t_overwrite;
    en = 1'b1;
    write(8'h11);
    idle(1);
    chk("R3 first take", rdy, 1'b1);
    write(8'h22);
    chk("R2 queued behind busy shifter", rdy, 1'b0);
    write(8'h33);
    chk("R6 rdy stays clear on overwrite", rdy, 1'b0);
    frame(8'h11, "R4 frame 11");
    idle(1);
    chk("R3 take pending", rdy, 1'b1);
    frame(8'h33, "R6 overwritten char sent");
    chk("R8 empty after 33", empty, 1'b1);
  endtask

  task automatic t_disable_mid;
    en = 1'b1;
    write(8'hC5);
    idle(1);
    write(8'h3C);
    pulse(5);
    en = 1'b0;
    frame_rest();
    idle(8);
    chk("R7 no load after disable", rdy, 1'b0);
    chk("R7 line high after frame", tx, 1'b1);
    chk("R8 empty low with held char", empty, 1'b0);
    en = 1'b1;
    idle(1);
    chk("R3 take after re-enable", rdy, 1'b1);
    frame(8'h3C, "R7 held char sent later");
  endtask

  // Finish the C5 frame with 5 ticks already spent on the start bit.
  task automatic frame_rest;
    chk("R7 start bit continues", tx, 1'b0);
    pulse(11);
    for (int b = 1; b < 10; b++) begin
      logic e;
      e = (b == 9) ? 1'b1 : 8'hC5 >> (b - 1);
      chk("R7 frame finishes while disabled", tx, e);
      pulse(16);
    end
  endtask

  initial begin
    idle(2);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_basic();
    t_no_tick();
    t_drop();
    t_overwrite();
    t_disable_mid();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule